// File: doc/BRIEF.md
# Dual-Channel Serial Register File with Indirect Pointer

This block is the byte-wide host side of a two-channel asynchronous serial controller. A host reaches each channel's sixteen write registers and sixteen read registers through two addresses per channel: a control address and a data address. Control accesses are two-step. The first write loads a per-channel register pointer. The next access to the control address hits the register that the pointer selects, and the pointer then clears itself.

The block stores the channel configuration and holds the power-on and software reset values. One register accepts reset commands that are acted on and never stored. From the stored configuration it decodes the line format (parity, stop bits, character length, clock multiplier, enables) and the total clock divisor, and drives them as plain outputs to a serializer and deserializer that sit outside the block. Data writes land in a per-channel transmit holding byte. Data reads return the byte that the deserializer offers.

Top module: `spr_regfile`

## Requirements
- R1: Address bit SEL_SHIFT selects control (0) or data (1), and bit SEL_SHIFT+1 selects the channel. Channel bit 0 addresses channel index 0 (channel B) and channel bit 1 addresses channel index 1 (channel A). An access to one channel never changes the other channel's state.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. When data bits 5:3 equal 3'b001 the pointer also gets 8 added. Any other value of bits 5:3 leaves the pointer in the range 0..7.
- R3: A control write while the pointer is nonzero writes the selected register and returns the pointer to 0. A control read returns the selected read register and returns the pointer to 0.
- R4: A write to register 9 stores nothing and acts on data bits 7:6. 2'b01 resets channel index 0, 2'b10 resets channel index 1, 2'b11 resets both, and 2'b00 has no effect. The writing channel's pointer returns to 0.
- R5: After asynchronous reset or a reset command, read register 0 reads 0x44 and read register 1 reads 0x07. Parity is off, one stop bit, x1 multiplier, 5-bit characters, transmitter and receiver off, divisor 2, transmit holding byte 0. The pointer is 0.
- R6: Read registers 12 and 13 return the last value written to write registers 12 (time constant low) and 13 (time constant high). Read registers 2 to 11, 14 and 15 read 0.
- R7: In register 4, bit 0 enables parity and bit 1 selects even parity. Bits 3:2 equal to 2'b11 select two stop bits. Bits 7:6 select the clock multiplier: 00 gives 1, 01 gives 16, 10 gives 32, 11 gives 64.
- R8: Register 5 bits 6:5 give the character length: 00 gives 5, 01 gives 7, 10 gives 6, 11 gives 8. Register 5 bit 3 enables the transmitter. Register 3 bit 0 enables the receiver.
- R9: The divisor output equals (time constant + 2) times the clock multiplier. The time constant is {register 13, register 12}.
- R10: A data write stores the byte in the channel's transmit holding output. A data read returns that channel's received-byte input. Neither access changes the pointer.
- R11: Read data appears on rdata_o one cycle after the read strobe and holds until the next accepted read. A write in the same cycle as a read takes priority, and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | SEL_SHIFT+2 | Byte address; bit SEL_SHIFT selects control/data, bit SEL_SHIFT+1 selects the channel |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rx_byte_i | input | 16 | Received byte per channel, index 0 in bits 7:0 |
| tx_hold_o | output | 16 | Transmit holding byte per channel |
| parity_en_o | output | 2 | Parity enable per channel |
| parity_even_o | output | 2 | Even parity select per channel |
| two_stop_o | output | 2 | Two stop bits per channel |
| char_bits_o | output | 8 | Character length (5..8) per channel, 4 bits each |
| clk_mult_o | output | 14 | Clock multiplier (1, 16, 32, 64) per channel, 7 bits each |
| tx_en_o | output | 2 | Transmitter enable per channel |
| rx_en_o | output | 2 | Receiver enable per channel |
| baud_div_o | output | 46 | Total clock divisor per channel, 23 bits each |

## Verification
Register 4 is swept through all 256 values on both channels. This separates the parity, stop-bit and multiplier fields and shows that the ignored bits 5:4 do not disturb them. A grid of time constants, from 0 and 0xFFFF to split byte patterns, is crossed with all four multipliers. It catches byte swaps between registers 12 and 13, the +2 offset and a wrong shift per multiplier. Command bytes with bits 5:3 at 001 and at other values show that only the point-high code adds 8. Reset codes 00, 01, 10 and 11 are issued from each channel against differently programmed channels, which shows which channel each code clears and that the writer's own settings survive.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int NCH    = 2;
  localparam int NREG   = 16;
  localparam int PTR_W  = 4;
  localparam int TC_W   = 16;
  localparam int MULT_W = 7;
  localparam int DIV_W  = TC_W + 1 + 6;

  localparam logic [PTR_W-1:0] REG_RXC   = 4'd3;
  localparam logic [PTR_W-1:0] REG_FMT   = 4'd4;
  localparam logic [PTR_W-1:0] REG_TXC   = 4'd5;
  localparam logic [PTR_W-1:0] REG_HOLD  = 4'd8;
  localparam logic [PTR_W-1:0] REG_RST   = 4'd9;
  localparam logic [PTR_W-1:0] REG_TC_LO = 4'd12;
  localparam logic [PTR_W-1:0] REG_TC_HI = 4'd13;

  localparam logic [2:0] CMD_PT_HIGH = 3'b001;
  localparam logic [7:0] RR0_RST = 8'h44;
  localparam logic [7:0] RR1_RST = 8'h07;

  typedef struct packed {
    logic            par_en;
    logic            par_even;
    logic [1:0]      stop;
    logic [1:0]      clk_mode;
    logic [1:0]      len;
    logic            tx_en;
    logic            rx_en;
    logic [TC_W-1:0] tc;
  } fmt_cfg_t;

  function automatic logic [7:0] wr_rst(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spr_chan.sv
module spr_chan
  import spr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             ctl_rd_i,
  input  logic             data_wr_i,
  input  logic             soft_rst_i,
  input  logic [7:0]       wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       rr_o,
  output fmt_cfg_t         cfg_o,
  output logic [7:0]       tx_hold_o
);
  logic [7:0]       wr_q [NREG];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_rst(i);
    end else if (soft_rst_i) begin
      ptr_q <= '0;
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_rst(i);
    end else begin
      if (ctl_wr_i) begin
        if (ptr_q == '0) begin
          ptr_q <= {wdata_i[5:3] == CMD_PT_HIGH, wdata_i[2:0]};
        end else begin
          ptr_q <= '0;
          // register 9 carries commands only
          if (ptr_q != REG_RST) wr_q[ptr_q] <= wdata_i;
        end
      end else if (ctl_rd_i) begin
        ptr_q <= '0;
      end
      if (data_wr_i) wr_q[REG_HOLD] <= wdata_i;
    end
  end

  always_comb begin
    case (ptr_q)
      4'd0:      rr_o = RR0_RST;
      4'd1:      rr_o = RR1_RST;
      REG_TC_LO: rr_o = wr_q[REG_TC_LO];
      REG_TC_HI: rr_o = wr_q[REG_TC_HI];
      default:   rr_o = 8'h00;
    endcase
  end

  assign ptr_o     = ptr_q;
  assign tx_hold_o = wr_q[REG_HOLD];

  assign cfg_o.par_en   = wr_q[REG_FMT][0];
  assign cfg_o.par_even = wr_q[REG_FMT][1];
  assign cfg_o.stop     = wr_q[REG_FMT][3:2];
  assign cfg_o.clk_mode = wr_q[REG_FMT][7:6];
  assign cfg_o.len      = wr_q[REG_TXC][6:5];
  assign cfg_o.tx_en    = wr_q[REG_TXC][3];
  assign cfg_o.rx_en    = wr_q[REG_RXC][0];
  assign cfg_o.tc       = {wr_q[REG_TC_HI], wr_q[REG_TC_LO]};

  AST_PTR_CLR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ptr_q != '0) |=> (ptr_q == '0)); // R3
  AST_PTR_CLR_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rd_i && !ctl_wr_i) |=> (ptr_q == '0)); // R3
  AST_PT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !soft_rst_i && ptr_q == '0 && wdata_i[5:3] == CMD_PT_HIGH)
      |=> ptr_q[PTR_W-1]); // R2
  AST_SOFT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ptr_q == '0 && tx_hold_o == 8'h00 && cfg_o.clk_mode == 2'b00
                    && cfg_o.tc == '0)); // R5
  AST_DATA_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !soft_rst_i) |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/spr_fmt.sv
module spr_fmt
  import spr_pkg::*;
(
  input  fmt_cfg_t            cfg_i,
  output logic                parity_en_o,
  output logic                parity_even_o,
  output logic                two_stop_o,
  output logic [3:0]          char_bits_o,
  output logic [MULT_W-1:0]   clk_mult_o,
  output logic                tx_en_o,
  output logic                rx_en_o,
  output logic [DIV_W-1:0]    baud_div_o
);
  logic [2:0] shift;

  always_comb begin
    case (cfg_i.clk_mode)
      2'b00:   shift = 3'd0;
      2'b01:   shift = 3'd4;
      2'b10:   shift = 3'd5;
      default: shift = 3'd6;
    endcase
    case (cfg_i.len)
      2'b00:   char_bits_o = 4'd5;
      2'b01:   char_bits_o = 4'd7;
      2'b10:   char_bits_o = 4'd6;
      default: char_bits_o = 4'd8;
    endcase
  end

  assign parity_en_o   = cfg_i.par_en;
  assign parity_even_o = cfg_i.par_even;
  assign two_stop_o    = (cfg_i.stop == 2'b11);
  assign tx_en_o       = cfg_i.tx_en;
  assign rx_en_o       = cfg_i.rx_en;
  assign clk_mult_o    = MULT_W'(1) << shift;
  assign baud_div_o    = (DIV_W'(cfg_i.tc) + DIV_W'(2)) << shift;
endmodule

// File: rtl/spr_regfile.sv
module spr_regfile
  import spr_pkg::*;
#(
  parameter int SEL_SHIFT = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SEL_SHIFT+1:0]    addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic [NCH*8-1:0]        rx_byte_i,
  output logic [NCH*8-1:0]        tx_hold_o,
  output logic [NCH-1:0]          parity_en_o,
  output logic [NCH-1:0]          parity_even_o,
  output logic [NCH-1:0]          two_stop_o,
  output logic [NCH*4-1:0]        char_bits_o,
  output logic [NCH*MULT_W-1:0]   clk_mult_o,
  output logic [NCH-1:0]          tx_en_o,
  output logic [NCH-1:0]          rx_en_o,
  output logic [NCH*DIV_W-1:0]    baud_div_o
);
  logic             sel_data;
  logic             ch;
  logic             rd_ok;
  logic [NCH-1:0]   ctl_wr, ctl_rd, data_wr, soft_rst;
  logic [PTR_W-1:0] ptr [NCH];
  logic [7:0]       rr  [NCH];
  fmt_cfg_t         cfg [NCH];
  logic             rst_cmd;
  logic [7:0]       rdata_q;

  assign sel_data = addr_i[SEL_SHIFT];
  assign ch       = addr_i[SEL_SHIFT+1];
  assign rd_ok    = rd_i && !wr_i;

  // reset command reaches both channels whichever channel carried it
  assign rst_cmd     = wr_i && !sel_data && (ptr[ch] == REG_RST);
  assign soft_rst[0] = rst_cmd && wdata_i[6];
  assign soft_rst[1] = rst_cmd && wdata_i[7];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl_wr[g]  = wr_i  && !sel_data && (ch == g[0]);
    assign ctl_rd[g]  = rd_ok && !sel_data && (ch == g[0]);
    assign data_wr[g] = wr_i  &&  sel_data && (ch == g[0]);

    spr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_wr_i   (ctl_wr[g]),
      .ctl_rd_i   (ctl_rd[g]),
      .data_wr_i  (data_wr[g]),
      .soft_rst_i (soft_rst[g]),
      .wdata_i    (wdata_i),
      .ptr_o      (ptr[g]),
      .rr_o       (rr[g]),
      .cfg_o      (cfg[g]),
      .tx_hold_o  (tx_hold_o[g*8 +: 8])
    );

    spr_fmt u_fmt (
      .cfg_i         (cfg[g]),
      .parity_en_o   (parity_en_o[g]),
      .parity_even_o (parity_even_o[g]),
      .two_stop_o    (two_stop_o[g]),
      .char_bits_o   (char_bits_o[g*4 +: 4]),
      .clk_mult_o    (clk_mult_o[g*MULT_W +: MULT_W]),
      .tx_en_o       (tx_en_o[g]),
      .rx_en_o       (rx_en_o[g]),
      .baud_div_o    (baud_div_o[g*DIV_W +: DIV_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= 8'h00;
    else if (rd_ok) rdata_q <= sel_data ? rx_byte_i[ch*8 +: 8] : rr[ch];
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok |=> $stable(rdata_o)); // R11
  AST_RST_ONEHOT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|soft_rst) |-> (wr_i && !sel_data)); // R4
endmodule

// File: tb/sim_spr_regfile.sv
module sim_spr_regfile;
  import spr_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] rx_byte = '0;
  logic [15:0] tx_hold;
  logic [1:0] par_en, par_even, two_stop, tx_en, rx_en;
  logic [7:0] char_bits;
  logic [13:0] clk_mult;
  logic [2*DIV_W-1:0] baud_div;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spr_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_byte_i(rx_byte), .tx_hold_o(tx_hold),
    .parity_en_o(par_en), .parity_even_o(par_even), .two_stop_o(two_stop),
    .char_bits_o(char_bits), .clk_mult_o(clk_mult), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .baud_div_o(baud_div)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic sel,
                     input logic c, input logic [7:0] d);
    @(negedge clk);
    addr = {c, sel}; wr = w; rd = r; wdata = d;
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic set_ptr(input logic c, input int r);
    bus(1, 0, 0, c, (r > 7) ? 8'(8'h08 | (r - 8)) : 8'(r));
  endtask

  task automatic wreg(input logic c, input int r, input logic [7:0] v);
    set_ptr(c, r);
    bus(1, 0, 0, c, v);
  endtask

  task automatic rreg(input logic c, input int r, output logic [7:0] v);
    if (r != 0) set_ptr(c, r);
    bus(0, 1, 0, c, 8'h00);
    v = rdata;
  endtask

  function automatic int exp_mult(input logic [1:0] m);
    return (m == 0) ? 1 : (1 << (m + 3));
  endfunction

  function automatic int exp_len(input logic [1:0] l);
    case (l)
      2'd0: return 5;
      2'd1: return 7;
      2'd2: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check_defaults(input string tag, input int c);
    logic [7:0] v;
    check({tag, " par_en"},   par_en[c], 0);
    check({tag, " two_stop"}, two_stop[c], 0);
    check({tag, " mult"},     clk_mult[c*7 +: 7], 1);
    check({tag, " len"},      char_bits[c*4 +: 4], 5);
    check({tag, " tx_en"},    tx_en[c], 0);
    check({tag, " rx_en"},    rx_en[c], 0);
    check({tag, " div"},      baud_div[c*DIV_W +: DIV_W], 2);
    check({tag, " hold"},     tx_hold[c*8 +: 8], 0);
    rreg(1'(c), 0, v); check({tag, " RR0"}, v, 8'h44);
    rreg(1'(c), 1, v); check({tag, " RR1"}, v, 8'h07);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, prev;
    repeat (3) @(negedge clk);
    check("R11 rdata after reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) check_defaults("R5 reset", c);

    // R7 full sweep of register 4
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 256; x++) begin
        wreg(1'(c), 4, 8'(x));
        check("R7 par_en",   par_en[c], x & 1);
        check("R7 par_even", par_even[c], (x >> 1) & 1);
        check("R7 two_stop", two_stop[c], ((x >> 2) & 3) == 3);
        check("R7 mult",     clk_mult[c*7 +: 7], exp_mult(2'(x >> 6)));
        check("R9 div tc0",  baud_div[c*DIV_W +: DIV_W], 2 * exp_mult(2'(x >> 6)));
      end

    // R8 length, tx and rx enables
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < 4; l++)
        for (int t = 0; t < 2; t++) begin
          wreg(1'(c), 5, 8'((l << 5) | (t << 3)));
          wreg(1'(c), 3, 8'(t));
          check("R8 len",   char_bits[c*4 +: 4], exp_len(2'(l)));
          check("R8 tx_en", tx_en[c], t);
          check("R8 rx_en", rx_en[c], t);
        end

    // R9 and R6 divisor grid and mirrors
    begin
      int tcs[6] = '{0, 1, 'h1234, 'hFFFF, 'h00FF, 'hFF00};
      for (int c = 0; c < 2; c++)
        foreach (tcs[k])
          for (int m = 0; m < 4; m++) begin
            wreg(1'(c), 12, 8'(tcs[k]));
            wreg(1'(c), 13, 8'(tcs[k] >> 8));
            wreg(1'(c), 4, 8'(m << 6));
            check("R9 div", baud_div[c*DIV_W +: DIV_W], (tcs[k] + 2) * exp_mult(2'(m)));
            rreg(1'(c), 12, v); check("R6 RR12", v, tcs[k] & 'hFF);
            rreg(1'(c), 13, v); check("R6 RR13", v, tcs[k] >> 8);
          end
    end

    // R2 non point-high command bits keep pointer low
    wreg(0, 12, 8'h5A);
    bus(1, 0, 0, 0, 8'h14);
    bus(1, 0, 0, 0, 8'hC0);
    check("R2 low ptr hits reg4", clk_mult[6:0], 64);
    rreg(0, 12, v); check("R2 reg12 untouched", v, 8'h5A);

    // R6 other read registers read zero
    for (int c = 0; c < 2; c++)
      for (int r = 2; r < 16; r++)
        if (r != 12 && r != 13) begin
          rreg(1'(c), r, v);
          check("R6 zero RR", v, 0);
        end

    // R3 pointer clears after write and read
    bus(1, 0, 0, 1, 8'h04);
    bus(1, 0, 0, 1, 8'h00);
    check("R3 write via ptr", clk_mult[13:7], 1);
    rreg(1, 0, v); check("R3 ptr 0 after write", v, 8'h44);
    rreg(1, 1, v); check("R3 RR1", v, 8'h07);
    rreg(1, 0, v); check("R3 ptr 0 after read", v, 8'h44);

    // R10 and R1 data path
    set_ptr(0, 1);
    bus(1, 0, 1, 0, 8'hA5);
    check("R10 hold ch0", tx_hold[7:0], 8'hA5);
    check("R1 hold ch1 untouched", tx_hold[15:8], 0);
    rx_byte = 16'h3CC3;
    bus(0, 1, 1, 0, 8'h00);
    check("R10 rx ch0", rdata, 8'hC3);
    bus(0, 1, 1, 1, 8'h00);
    check("R10 rx ch1", rdata, 8'h3C);
    rreg(0, 0, v); check("R10 ptr kept by data", v, 8'h07);
    bus(1, 0, 1, 1, 8'h96);
    check("R10 hold ch1", tx_hold[15:8], 8'h96);

    // R11 hold between reads and on write priority
    prev = rdata;
    repeat (3) @(negedge clk);
    check("R11 hold idle", rdata, prev);
    bus(1, 1, 0, 0, 8'h03);
    check("R11 write wins", rdata, prev);
    bus(0, 1, 0, 0, 8'h00);
    check("R11 read selected RR3", rdata, 0);

    // R4 reset commands
    for (int c = 0; c < 2; c++) begin
      wreg(1'(c), 4, 8'hC3); wreg(1'(c), 12, 8'h00); wreg(1'(c), 13, 8'h01);
      wreg(1'(c), 5, 8'h08); bus(1, 0, 1, 1'(c), 8'h77);
    end
    wreg(1, 9, 8'h40);
    check_defaults("R4 code01 resets ch0", 0);
    check("R4 ch1 kept mult", clk_mult[13:7], 64);
    check("R4 ch1 kept div", baud_div[DIV_W +: DIV_W], (256 + 2) * 64);
    check("R4 ch1 kept hold", tx_hold[15:8], 8'h77);
    rreg(1, 0, v); check("R4 writer ptr 0", v, 8'h44);
    wreg(0, 4, 8'hC3); wreg(0, 5, 8'h08);
    wreg(0, 9, 8'h80);
    check_defaults("R4 code10 resets ch1", 1);
    check("R4 ch0 kept mult", clk_mult[6:0], 64);
    check("R4 ch0 kept tx_en", tx_en[0], 1);
    wreg(1, 4, 8'h41);
    wreg(1, 9, 8'h00);
    check("R4 code00 ch1 kept", clk_mult[13:7], 16);
    check("R4 code00 ch0 kept", clk_mult[6:0], 64);
    rreg(1, 0, v); check("R4 code00 ptr 0", v, 8'h44);
    wreg(0, 9, 8'hC0);
    check_defaults("R4 code11 ch0", 0);
    check_defaults("R4 code11 ch1", 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule